// File: doc/BRIEF.md
# Machine-Mode Trap and Interrupt CSR File

This block holds the machine-level trap state of a small 32-bit core. It contains the status fields that gate and stack the global interrupt enable, the trap-vector register, the exception PC and cause registers, and the interrupt enable and pending registers. The interrupt registers cover the software, timer and external lines plus fifteen local fast lines. There is no separate interrupt controller: the fast lines are enabled and observed through the same two registers. The controller reads the block's arbitration result to decide when to take an interrupt. It strobes trap entry, NMI entry, normal return and NMI return. The block answers with the handler address, the saved PC and the updated state one clock later.

A hidden backup context holds the previous privilege, previous enable, exception PC and cause. It is filled on NMI entry and drained on NMI return, so an NMI that lands inside a trap handler can return without losing that handler's context. No CSR address reaches it. The trap-vector base can be rewritten at run time, is kept 256-byte aligned, and starts from the boot address after reset.

Top module: `mtrap_csr`

## Requirements
- R1: After reset, the trap-vector register reads as boot_addr_i with bits 7:0 cleared and direct mode. Status reads 0x1800 (previous privilege = machine, both enables 0). The enable register, exception PC and cause all read 0.
- R2: The trap-vector register (address 0x305) keeps write bits 31:8 as the base and bit 0 as the mode (1 = vectored). Bits 7:1 always read 0.
- R3: Status (0x300) has the global enable at bit 3, the previous enable at bit 7 and the previous privilege at bits 12:11. A privilege write other than 2'b11 is stored as 2'b00. All other status bits read 0.
- R4: The enable register (0x304) stores only bits 3 (software), 7 (timer), 11 (external) and 16..30 (fast lines 0..14). All other bits read 0.
- R5: The pending register (0x344) shows the raw lines at the same bit positions and ignores writes.
- R6: irq_req_o rises in the same cycle when the global enable is 1 and some line is both pending and enabled. It stays low if either condition is missing.
- R7: irq_id_o names the winner. An active irq_nmi_i always wins, with ID 31, regardless of any enable. Otherwise the highest-indexed fast line wins (ID 16+i), then external (11), then software (3), then timer (7).
- R8: On trap_enter_i, the next cycle shows: exception PC = trap_pc_i with bit 0 cleared, whatever the instruction was (for a malformed indirect jump this is the faulting PC, never its target); cause = {trap_irq_i, 26'b0, trap_cause_i}; previous enable = old global enable; global enable = 0; previous privilege = 2'b11. epc_o mirrors the exception PC.
- R9: trap_addr_o is the base in direct mode or for exceptions. In vectored mode for an interrupt it is base + 4 × cause.
- R10: On mret_i, the global enable takes the previous enable, the previous enable becomes 1, and the previous privilege is unchanged.
- R11: On nmi_enter_i, the old previous privilege, previous enable, exception PC and cause are saved in the backup. A trap entry with interrupt cause 31 follows, and trap_addr_o uses cause 31 in that cycle.
- R12: On nmi_ret_i, the global enable takes the previous enable. The previous privilege, previous enable, exception PC and cause take the backed-up values.
- R13: The backup is not reachable through the CSR port: every unmapped address reads 0.
- R14: In a cycle with any trap or return strobe, a CSR write to status, exception PC or cause is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boot_addr_i | input | 32 | Boot address, reset source of the trap-vector base |
| csr_addr_i | input | 12 | CSR address |
| csr_we_i | input | 1 | CSR write enable |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data (combinational) |
| irq_software_i | input | 1 | Machine software interrupt line |
| irq_timer_i | input | 1 | Machine timer interrupt line |
| irq_external_i | input | 1 | Machine external interrupt line |
| irq_fast_i | input | 15 | Local fast interrupt lines |
| irq_nmi_i | input | 1 | Non-maskable interrupt line |
| trap_enter_i | input | 1 | Trap entry strobe |
| trap_irq_i | input | 1 | Trap is an interrupt |
| trap_cause_i | input | 5 | Trap cause code |
| trap_pc_i | input | 32 | PC to save on entry |
| nmi_enter_i | input | 1 | NMI entry strobe |
| mret_i | input | 1 | Normal return strobe |
| nmi_ret_i | input | 1 | NMI return strobe |
| trap_addr_o | output | 32 | Handler address |
| epc_o | output | 32 | Saved PC for return |
| irq_req_o | output | 1 | Interrupt request |
| irq_id_o | output | 5 | Winning interrupt ID |

## Verification
A corrupted enable, pending or global-enable bit shows at irq_req_o or irq_id_o in the same cycle, so the line sweeps check the arbitration combinationally for every single line and every pair of lines. A wrong stacking update shows in the status, exception PC or cause read one cycle after the strobe. A wrong backup shows only after the matching NMI return, which the bench reaches within a few cycles by nesting an NMI inside an ordinary trap with distinctive saved values. A full read sweep of the address space then confirms that those saved values appear at no address other than the architectural ones.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
  localparam int XLEN = 32;

  localparam logic [11:0] CSR_MSTATUS = 12'h300;
  localparam logic [11:0] CSR_MIE     = 12'h304;
  localparam logic [11:0] CSR_MTVEC   = 12'h305;
  localparam logic [11:0] CSR_MEPC    = 12'h341;
  localparam logic [11:0] CSR_MCAUSE  = 12'h342;
  localparam logic [11:0] CSR_MIP     = 12'h344;

  localparam int BIT_MSI   = 3;
  localparam int BIT_MTI   = 7;
  localparam int BIT_MEI   = 11;
  localparam int BIT_FAST0 = 16;

  localparam int ST_MIE  = 3;
  localparam int ST_MPIE = 7;
  localparam int ST_MPP  = 11;

  localparam logic [4:0] NMI_ID = 5'd31;
  localparam logic [1:0] PRIV_M = 2'b11;
  localparam logic [1:0] PRIV_U = 2'b00;

  typedef struct packed {
    logic       irq;
    logic [4:0] code;
  } cause_t;

  typedef struct packed {
    logic [1:0]      mpp;
    logic            mpie;
    logic [XLEN-1:0] mepc;
    cause_t          mcause;
  } trap_ctx_t;
endpackage

// File: rtl/mtrap_irq_arb.sv
module mtrap_irq_arb
  import mtrap_pkg::*;
#(
  parameter int NUM_FAST = 15
) (
  input  logic                nmi_i,
  input  logic                gie_i,
  input  logic                msi_i,
  input  logic                mti_i,
  input  logic                mei_i,
  input  logic [NUM_FAST-1:0] fast_i,
  output logic                req_o,
  output logic [4:0]          id_o
);
  logic       any;
  logic [4:0] id;

  // lowest priority first, later hits override
  always_comb begin
    any = 1'b0;
    id  = '0;
    if (mti_i) begin any = 1'b1; id = 5'(BIT_MTI); end
    if (msi_i) begin any = 1'b1; id = 5'(BIT_MSI); end
    if (mei_i) begin any = 1'b1; id = 5'(BIT_MEI); end
    for (int i = 0; i < NUM_FAST; i++) begin
      if (fast_i[i]) begin any = 1'b1; id = 5'(BIT_FAST0 + i); end
    end
  end

  assign req_o = nmi_i | (gie_i & any);
  assign id_o  = nmi_i ? NMI_ID : id;
endmodule

// File: rtl/mtrap_vec.sv
module mtrap_vec
  import mtrap_pkg::*;
#(
  parameter int VEC_ALIGN = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [XLEN-1:0] boot_addr_i,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            is_irq_i,
  input  logic [4:0]      code_i,
  output logic [XLEN-1:0] mtvec_o,
  output logic [XLEN-1:0] trap_addr_o
);
  localparam int BASE_W = XLEN - VEC_ALIGN;

  logic [BASE_W-1:0] base_q;
  logic              mode_q;
  logic [XLEN-1:0]   base_addr, offset;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= boot_addr_i[XLEN-1:VEC_ALIGN];
      mode_q <= 1'b0;
    end else if (we_i) begin
      base_q <= wdata_i[XLEN-1:VEC_ALIGN];
      mode_q <= wdata_i[0];
    end
  end

  assign mtvec_o     = {base_q, {(VEC_ALIGN-1){1'b0}}, mode_q};
  assign base_addr   = {base_q, {VEC_ALIGN{1'b0}}};
  assign offset      = (mode_q && is_irq_i) ? {{(XLEN-7){1'b0}}, code_i, 2'b00} : '0;
  assign trap_addr_o = base_addr + offset;

  logic unused_vec;
  assign unused_vec = ^{boot_addr_i[VEC_ALIGN-1:0], wdata_i[VEC_ALIGN-1:1]};
endmodule

// File: rtl/mtrap_nmi_stack.sv
module mtrap_nmi_stack
  import mtrap_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      push_i,
  input  trap_ctx_t ctx_i,
  output trap_ctx_t ctx_o
);
  trap_ctx_t bk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bk_q <= '0;
    else if (push_i) bk_q <= ctx_i;
  end

  assign ctx_o = bk_q;
endmodule

// File: rtl/mtrap_csr.sv
module mtrap_csr
  import mtrap_pkg::*;
#(
  parameter int NUM_FAST  = 15,
  parameter int VEC_ALIGN = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [XLEN-1:0]     boot_addr_i,
  input  logic [11:0]         csr_addr_i,
  input  logic                csr_we_i,
  input  logic [XLEN-1:0]     csr_wdata_i,
  output logic [XLEN-1:0]     csr_rdata_o,
  input  logic                irq_software_i,
  input  logic                irq_timer_i,
  input  logic                irq_external_i,
  input  logic [NUM_FAST-1:0] irq_fast_i,
  input  logic                irq_nmi_i,
  input  logic                trap_enter_i,
  input  logic                trap_irq_i,
  input  logic [4:0]          trap_cause_i,
  input  logic [XLEN-1:0]     trap_pc_i,
  input  logic                nmi_enter_i,
  input  logic                mret_i,
  input  logic                nmi_ret_i,
  output logic [XLEN-1:0]     trap_addr_o,
  output logic [XLEN-1:0]     epc_o,
  output logic                irq_req_o,
  output logic [4:0]          irq_id_o
);
  localparam logic [XLEN-1:0] IRQ_MASK =
      XLEN'((1 << BIT_MSI) | (1 << BIT_MTI) | (1 << BIT_MEI)) |
      (XLEN'((1 << NUM_FAST) - 1) << BIT_FAST0);

  logic            gie_q, mpie_q;
  logic [1:0]      mpp_q;
  logic [XLEN-1:0] mepc_q, ien_q, mip_w, mtvec_w, mstatus_w, act_w;
  cause_t          mcause_q;
  trap_ctx_t       bk_ctx, cur_ctx;

  logic ev_enter, ev_any, ent_irq;
  logic [4:0] ent_code;
  logic we_status, we_ien, we_tvec, we_epc, we_cause;

  assign ev_enter = trap_enter_i | nmi_enter_i;
  assign ev_any   = ev_enter | mret_i | nmi_ret_i;
  assign ent_irq  = nmi_enter_i | trap_irq_i;
  assign ent_code = nmi_enter_i ? NMI_ID : trap_cause_i;

  // stacking events own status/epc/cause for the cycle
  assign we_status = csr_we_i && csr_addr_i == CSR_MSTATUS && !ev_any;
  assign we_epc    = csr_we_i && csr_addr_i == CSR_MEPC    && !ev_any;
  assign we_cause  = csr_we_i && csr_addr_i == CSR_MCAUSE  && !ev_any;
  assign we_ien    = csr_we_i && csr_addr_i == CSR_MIE;
  assign we_tvec   = csr_we_i && csr_addr_i == CSR_MTVEC;

  always_comb begin
    mip_w = '0;
    mip_w[BIT_MSI] = irq_software_i;
    mip_w[BIT_MTI] = irq_timer_i;
    mip_w[BIT_MEI] = irq_external_i;
    mip_w[BIT_FAST0 +: NUM_FAST] = irq_fast_i;
  end

  assign act_w = mip_w & ien_q;

  always_comb begin
    mstatus_w = '0;
    mstatus_w[ST_MIE]          = gie_q;
    mstatus_w[ST_MPIE]         = mpie_q;
    mstatus_w[ST_MPP +: 2]     = mpp_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q    <= 1'b0;
      mpie_q   <= 1'b0;
      mpp_q    <= PRIV_M;
      mepc_q   <= '0;
      mcause_q <= '0;
    end else if (ev_enter) begin
      mepc_q   <= {trap_pc_i[XLEN-1:1], 1'b0};
      mcause_q <= '{irq: ent_irq, code: ent_code};
      mpie_q   <= gie_q;
      gie_q    <= 1'b0;
      mpp_q    <= PRIV_M;
    end else if (nmi_ret_i) begin
      gie_q    <= mpie_q;
      mpie_q   <= bk_ctx.mpie;
      mpp_q    <= bk_ctx.mpp;
      mepc_q   <= bk_ctx.mepc;
      mcause_q <= bk_ctx.mcause;
    end else if (mret_i) begin
      gie_q    <= mpie_q;
      mpie_q   <= 1'b1;
    end else begin
      if (we_status) begin
        gie_q  <= csr_wdata_i[ST_MIE];
        mpie_q <= csr_wdata_i[ST_MPIE];
        mpp_q  <= (csr_wdata_i[ST_MPP +: 2] == PRIV_M) ? PRIV_M : PRIV_U;
      end
      if (we_epc)   mepc_q   <= {csr_wdata_i[XLEN-1:1], 1'b0};
      if (we_cause) mcause_q <= '{irq: csr_wdata_i[XLEN-1], code: csr_wdata_i[4:0]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ien_q <= '0;
    else if (we_ien) ien_q <= csr_wdata_i & IRQ_MASK;
  end

  assign cur_ctx = '{mpp: mpp_q, mpie: mpie_q, mepc: mepc_q, mcause: mcause_q};

  mtrap_nmi_stack u_stack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (nmi_enter_i),
    .ctx_i  (cur_ctx),
    .ctx_o  (bk_ctx)
  );

  mtrap_vec #(.VEC_ALIGN(VEC_ALIGN)) u_vec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .boot_addr_i (boot_addr_i),
    .we_i        (we_tvec),
    .wdata_i     (csr_wdata_i),
    .is_irq_i    (ent_irq),
    .code_i      (ent_code),
    .mtvec_o     (mtvec_w),
    .trap_addr_o (trap_addr_o)
  );

  mtrap_irq_arb #(.NUM_FAST(NUM_FAST)) u_arb (
    .nmi_i  (irq_nmi_i),
    .gie_i  (gie_q),
    .msi_i  (act_w[BIT_MSI]),
    .mti_i  (act_w[BIT_MTI]),
    .mei_i  (act_w[BIT_MEI]),
    .fast_i (act_w[BIT_FAST0 +: NUM_FAST]),
    .req_o  (irq_req_o),
    .id_o   (irq_id_o)
  );

  always_comb begin
    unique case (csr_addr_i)
      CSR_MSTATUS: csr_rdata_o = mstatus_w;
      CSR_MIE:     csr_rdata_o = ien_q;
      CSR_MTVEC:   csr_rdata_o = mtvec_w;
      CSR_MEPC:    csr_rdata_o = mepc_q;
      CSR_MCAUSE:  csr_rdata_o = {mcause_q.irq, {(XLEN-6){1'b0}}, mcause_q.code};
      CSR_MIP:     csr_rdata_o = mip_w;
      default:     csr_rdata_o = '0;
    endcase
  end

  assign epc_o = mepc_q;

  logic unused_top;
  assign unused_top = ^{trap_pc_i[0], act_w};

  a_r2_tvec_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_addr_i == CSR_MTVEC |-> csr_rdata_o[VEC_ALIGN-1:1] == '0);

  a_r6_req_needs_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && !irq_nmi_i) |-> gie_q);

  a_r7_nmi_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_nmi_i |-> (irq_req_o && irq_id_o == NMI_ID));

  a_r8_entry_stacks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_enter |=> (!gie_q && mpp_q == PRIV_M && mpie_q == $past(gie_q)));

  a_r10_mret: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mret_i && !ev_enter && !nmi_ret_i) |=> (gie_q == $past(mpie_q) && mpie_q));

  a_r11_backup_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_enter_i |=> (bk_ctx.mepc == $past(mepc_q) && bk_ctx.mpp == $past(mpp_q)));

  a_r12_nmi_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_ret_i && !ev_enter) |=> (mepc_q == $past(bk_ctx.mepc) && mpie_q == $past(bk_ctx.mpie)));

  a_r4_ien_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q & ~IRQ_MASK) == '0);
endmodule

// File: tb/tb_mtrap_csr.sv
module tb_mtrap_csr;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] boot_addr_i = 32'h1234_56AB;
  logic [11:0] csr_addr_i = '0;
  logic        csr_we_i = 1'b0;
  logic [31:0] csr_wdata_i = '0;
  logic [31:0] csr_rdata_o;
  logic [17:0] ln = '0;
  logic        irq_nmi_i = 1'b0;
  logic        trap_enter_i = 1'b0, trap_irq_i = 1'b0;
  logic [4:0]  trap_cause_i = '0;
  logic [31:0] trap_pc_i = '0;
  logic        nmi_enter_i = 1'b0, mret_i = 1'b0, nmi_ret_i = 1'b0;
  logic [31:0] trap_addr_o, epc_o;
  logic        irq_req_o;
  logic [4:0]  irq_id_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  mtrap_csr dut (
    .clk_i, .rst_ni, .boot_addr_i, .csr_addr_i, .csr_we_i, .csr_wdata_i, .csr_rdata_o,
    .irq_software_i(ln[0]), .irq_timer_i(ln[1]), .irq_external_i(ln[2]),
    .irq_fast_i(ln[17:3]), .irq_nmi_i, .trap_enter_i, .trap_irq_i, .trap_cause_i,
    .trap_pc_i, .nmi_enter_i, .mret_i, .nmi_ret_i, .trap_addr_o, .epc_o,
    .irq_req_o, .irq_id_o
  );

  // line k: 0 software, 1 timer, 2 external, 3.. fast
  function automatic int line_id(int k);
    if (k == 0) return 3;
    if (k == 1) return 7;
    if (k == 2) return 11;
    return k + 13;
  endfunction

  function automatic int line_rank(int k);
    if (k == 1) return 0;
    if (k == 0) return 1;
    return k;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    csr_addr_i = a; csr_wdata_i = d; csr_we_i = 1'b1;
    tick();
    csr_we_i = 1'b0;
  endtask

  task automatic rd(string tag, logic [11:0] a, logic [31:0] exp);
    csr_addr_i = a; #1;
    chk(tag, csr_rdata_o, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    #22 rst_ni = 1'b1;
    tick();
    // R1 reset values
    rd("R1 mtvec", 12'h305, 32'h1234_5600);
    rd("R1 mstatus", 12'h300, 32'h0000_1800);
    rd("R1 mie", 12'h304, 32'h0);
    rd("R1 mepc", 12'h341, 32'h0);
    rd("R1 mcause", 12'h342, 32'h0);
    chk("R1 epc_o", epc_o, 32'h0);
    chk("R1 req", {31'b0, irq_req_o}, 32'h0);

    // R2 trap-vector alignment and mode
    wr(12'h305, 32'hFFFF_FFFF);
    rd("R2 all ones", 12'h305, 32'hFFFF_FF01);
    wr(12'h305, 32'h0000_2A7E);
    rd("R2 low ignored", 12'h305, 32'h0000_2A00);

    // R3 status fields
    wr(12'h300, 32'hFFFF_FFFF);
    rd("R3 all ones", 12'h300, 32'h0000_1888);
    wr(12'h300, 32'h0000_0808);
    rd("R3 mpp 01->00", 12'h300, 32'h0000_0008);
    wr(12'h300, 32'h0000_1000);
    rd("R3 mpp 10->00", 12'h300, 32'h0000_0000);

    // R4 enable mask
    wr(12'h304, 32'hFFFF_FFFF);
    rd("R4 mask", 12'h304, 32'h7FFF_0888);

    // R5 pending mirrors lines, writes ignored
    for (int k = 0; k < 18; k++) begin
      ln = 18'(1) << k;
      rd($sformatf("R5 line %0d", k), 12'h344, 32'(1) << line_id(k));
    end
    ln = '0;
    wr(12'h344, 32'hFFFF_FFFF);
    rd("R5 write ignored", 12'h344, 32'h0);

    // R6 gating with global enable off
    wr(12'h300, 32'h0);
    for (int k = 0; k < 18; k++) begin
      ln = 18'(1) << k; #1;
      chk($sformatf("R6 gie0 line %0d", k), {31'b0, irq_req_o}, 32'h0);
    end
    ln = '0;
    wr(12'h300, 32'h8);
    // R6 gating by per-line enable
    for (int k = 0; k < 18; k++) begin
      wr(12'h304, 32'h7FFF_0888 & ~(32'(1) << line_id(k)));
      ln = 18'(1) << k; #1;
      chk($sformatf("R6 en0 line %0d", k), {31'b0, irq_req_o}, 32'h0);
      ln = '0;
    end
    wr(12'h304, 32'hFFFF_FFFF);
    // R7 all pairs
    for (int a = 0; a < 18; a++) begin
      for (int b = 0; b < 18; b++) begin
        int w;
        ln = (18'(1) << a) | (18'(1) << b); #1;
        w = (line_rank(a) >= line_rank(b)) ? a : b;
        chk($sformatf("R6 req %0d/%0d", a, b), {31'b0, irq_req_o}, 32'h1);
        chk($sformatf("R7 id %0d/%0d", a, b), {27'b0, irq_id_o}, 32'(line_id(w)));
      end
    end
    // R7 NMI wins even masked
    ln = 18'h3FFFF; irq_nmi_i = 1'b1; #1;
    chk("R7 nmi over all", {26'b0, irq_req_o, irq_id_o}, {26'b0, 1'b1, 5'd31});
    ln = '0;
    wr(12'h304, 32'h0);
    wr(12'h300, 32'h0);
    chk("R7 nmi masked", {26'b0, irq_req_o, irq_id_o}, {26'b0, 1'b1, 5'd31});
    irq_nmi_i = 1'b0;

    // R9 handler address
    wr(12'h305, 32'h8000_0101);
    for (int c = 0; c < 32; c++) begin
      trap_cause_i = 5'(c);
      trap_irq_i = 1'b1; #1;
      chk($sformatf("R9 vec irq %0d", c), trap_addr_o, 32'h8000_0100 + 32'(4 * c));
      trap_irq_i = 1'b0; #1;
      chk($sformatf("R9 vec exc %0d", c), trap_addr_o, 32'h8000_0100);
    end
    wr(12'h305, 32'h8000_0100);
    trap_irq_i = 1'b1; trap_cause_i = 5'd11; #1;
    chk("R9 direct irq", trap_addr_o, 32'h8000_0100);
    wr(12'h305, 32'h8000_0101);

    // R8 trap entry, malformed jump: faulting pc saved
    wr(12'h300, 32'h8);
    trap_enter_i = 1'b1; trap_irq_i = 1'b0; trap_cause_i = 5'd2; trap_pc_i = 32'h0000_4003;
    tick();
    trap_enter_i = 1'b0;
    rd("R8 mepc", 12'h341, 32'h0000_4002);
    chk("R8 epc_o", epc_o, 32'h0000_4002);
    rd("R8 mcause", 12'h342, 32'h0000_0002);
    rd("R8 mstatus", 12'h300, 32'h0000_1880);

    // R10 return
    mret_i = 1'b1; tick(); mret_i = 1'b0;
    rd("R10 mstatus", 12'h300, 32'h0000_1888);

    // R11 NMI inside a trap handler
    trap_enter_i = 1'b1; trap_irq_i = 1'b1; trap_cause_i = 5'd11; trap_pc_i = 32'h0000_0100;
    tick();
    trap_enter_i = 1'b0; trap_irq_i = 1'b0;
    rd("R8 irq mcause", 12'h342, 32'h8000_000B);
    wr(12'h300, 32'h0000_0080);
    nmi_enter_i = 1'b1; trap_pc_i = 32'h0000_0204; trap_cause_i = 5'd0; #1;
    chk("R11 nmi vector", trap_addr_o, 32'h8000_017C);
    tick();
    nmi_enter_i = 1'b0;
    rd("R11 mepc", 12'h341, 32'h0000_0204);
    rd("R11 mcause", 12'h342, 32'h8000_001F);
    rd("R11 mstatus", 12'h300, 32'h0000_1800);

    // R13 backup invisible
    for (int a = 0; a < 4096; a++) begin
      logic [11:0] ad;
      ad = 12'(a);
      if (ad != 12'h300 && ad != 12'h304 && ad != 12'h305 &&
          ad != 12'h341 && ad != 12'h342 && ad != 12'h344)
        rd($sformatf("R13 addr %h", ad), ad, 32'h0);
    end

    // R12 NMI return restores
    nmi_ret_i = 1'b1; tick(); nmi_ret_i = 1'b0;
    rd("R12 mepc", 12'h341, 32'h0000_0100);
    chk("R12 epc_o", epc_o, 32'h0000_0100);
    rd("R12 mcause", 12'h342, 32'h8000_000B);
    rd("R12 mstatus", 12'h300, 32'h0000_0080);

    // R14 event beats CSR write
    csr_addr_i = 12'h341; csr_wdata_i = 32'hDEAD_0000; csr_we_i = 1'b1;
    trap_enter_i = 1'b1; trap_irq_i = 1'b0; trap_cause_i = 5'd5; trap_pc_i = 32'h0000_0300;
    tick();
    csr_we_i = 1'b0; trap_enter_i = 1'b0;
    rd("R14 mepc", 12'h341, 32'h0000_0300);
    csr_addr_i = 12'h300; csr_wdata_i = 32'h0000_0008; csr_we_i = 1'b1; mret_i = 1'b1;
    tick();
    csr_we_i = 1'b0; mret_i = 1'b0;
    rd("R14 mstatus", 12'h300, 32'h0000_1880);

    finish_run();
  end
endmodule